// File: doc/BRIEF.md
# Decimal Step Counter with Seven-Segment Output

This block keeps a single decimal digit, 0 through 9, and moves it on every rising clock edge by an amount picked by a two-bit step code. The code can hold the digit, move it up by one, move it up by two, or move it down by one. The digit wraps inside the decimal range in both directions, so it never leaves 0..9.

A synchronous reset, active low, returns the digit to zero. The current digit is available in binary. It is also available as an active-low seven-segment pattern, decoded combinationally, so that it can drive one display digit directly.

Top module: `dec_step_counter`

## Requirements
- R1: While rst_n is low at a rising clock edge, the count becomes 0 after that edge, whatever step code is applied.
- R2: Step code 2'b00 leaves the count unchanged across the edge.
- R3: Step code 2'b01 makes the next count (count+1) mod 10, so 9 goes to 0.
- R4: Step code 2'b10 makes the next count (count+2) mod 10, so 8 goes to 0 and 9 goes to 1.
- R5: Step code 2'b11 makes the next count (count+9) mod 10, so 0 goes to 9.
- R6: The count changes only at a rising clock edge. A change of step or rst_n between edges does not alter it.
- R7: The count never exceeds 9.
- R8: seg_n is active low, with bit 0 = segment a through bit 6 = segment g. It shows the standard pattern of the current digit: 0=7'h40, 1=7'h79, 2=7'h24, 3=7'h30, 4=7'h19, 5=7'h12, 6=7'h02, 7=7'h78, 8=7'h00, 9=7'h10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step | input | 2 | Step code: hold, +1, +2, -1 |
| count | output | 4 | Current decimal digit |
| seg_n | output | 7 | Active-low segments a..g of the digit |

## Verification
The bench targets the wrap points: 9 stepped by one, 8 and 9 stepped by two, and 0 stepped down. A design that uses plain binary arithmetic would show 10, 11 or 15 at these points instead of wrapping. Reset is applied together with every step code, which would expose a reset that loses priority to counting. Inputs are also toggled between edges, which would catch a count that follows the inputs combinationally. Every digit's segment pattern is compared with a table kept in the bench, which catches swapped segments or the wrong polarity.

// File: rtl/dec_step_counter.sv
module dec_step_counter #(
  parameter int MODULUS = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] step,
  output logic [3:0] count,
  output logic [6:0] seg_n
);
  localparam logic [3:0] TOP = 4'(MODULUS - 1);

  logic [4:0] sum;
  logic [3:0] nxt;

  always_comb begin
    unique case (step)
      2'b00: sum = {1'b0, count};
      2'b01: sum = {1'b0, count} + 5'd1;
      2'b10: sum = {1'b0, count} + 5'd2;
      default: sum = {1'b0, count} + 5'(MODULUS - 1);
    endcase
  end

  assign nxt = (sum >= 5'(MODULUS)) ? 4'(sum - 5'(MODULUS)) : sum[3:0];

  always_ff @(posedge clk) begin
    if (!rst_n) count <= '0;
    else        count <= nxt;
  end

  always_comb begin
    case (count)
      4'd0: seg_n = 7'h40;
      4'd1: seg_n = 7'h79;
      4'd2: seg_n = 7'h24;
      4'd3: seg_n = 7'h30;
      4'd4: seg_n = 7'h19;
      4'd5: seg_n = 7'h12;
      4'd6: seg_n = 7'h02;
      4'd7: seg_n = 7'h78;
      4'd8: seg_n = 7'h00;
      4'd9: seg_n = 7'h10;
      default: seg_n = 7'h7f;
    endcase
  end

  // R1
  reset_zero_chk: assert property (@(posedge clk) !rst_n |=> count == 4'd0);
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'b00) |=> $stable(count));
  // R3
  inc1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'b01 && count <= TOP) |=> count == (($past(count) == TOP) ? 4'd0 : $past(count) + 4'd1));
  // R5
  dec1_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 2'b11 && count <= TOP) |=> count == (($past(count) == 4'd0) ? TOP : $past(count) - 4'd1));
  // R7
  range_chk: assert property (@(posedge clk) disable iff (!rst_n) count <= TOP);
endmodule

// File: tb/dec_step_counter_test.sv
module dec_step_counter_test;
  logic clk = 0, rst_n = 0;
  logic [1:0] step = 0;
  logic [3:0] count;
  logic [6:0] seg_n;
  int errors = 0, checks = 0;
  int model = 0;
  bit done = 0;

  dec_step_counter uut (.clk(clk), .rst_n(rst_n), .step(step), .count(count), .seg_n(seg_n));

  always #4 clk = ~clk;

  function automatic int next_val(int v, logic [1:0] s);
    case (s)
      2'b00: return v;
      2'b01: return (v + 1) % 10;
      2'b10: return (v + 2) % 10;
      default: return (v + 9) % 10;
    endcase
  endfunction

  function automatic logic [6:0] seg_of(int d);
    logic [6:0] t[10] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19, 7'h12, 7'h02, 7'h78, 7'h00, 7'h10};
    return t[d];
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_state(string req);
    chk(req, count, model);
    chk("R7", int'(count <= 4'd9), 1);
    chk("R8", seg_n, seg_of(model));
  endtask

  task automatic cycle(logic r, logic [1:0] s, string req);
    rst_n = r; step = s;
    @(posedge clk); #2;
    model = r ? next_val(model, s) : 0;
    check_state(req);
  endtask

  task automatic walk_to(int target);
    while (model != target) cycle(1, 2'b01, "R3");
  endtask

  initial begin
    process::self().srandom(32'd1234);
    @(posedge clk); #2;
    model = 0;
    check_state("R1");
    for (int s = 0; s < 4; s++) begin
      walk_to(5);
      cycle(0, 2'(s), "R1");
    end
    walk_to(9); cycle(1, 2'b01, "R3");
    walk_to(8); cycle(1, 2'b10, "R4");
    walk_to(9); cycle(1, 2'b10, "R4");
    walk_to(0); cycle(1, 2'b11, "R5");
    cycle(1, 2'b00, "R2");
    cycle(1, 2'b11, "R5");
    // R6: inputs toggled mid-cycle must not move count
    #1 step = 2'b10; rst_n = 0; #1;
    chk("R6", count, model);
    step = 2'b01; rst_n = 1; #1;
    chk("R6", count, model);
    rst_n = 1; step = 2'b00;
    for (int d = 0; d < 10; d++) begin
      walk_to(d);
      chk("R8", seg_n, seg_of(d));
    end
    for (int i = 0; i < 400; i++) begin
      logic [1:0] s;
      logic r;
      s = 2'($urandom_range(0, 3));
      r = ($urandom_range(0, 19) != 0);
      case (s)
        2'b00: cycle(r, s, r ? "R2" : "R1");
        2'b01: cycle(r, s, r ? "R3" : "R1");
        2'b10: cycle(r, s, r ? "R4" : "R1");
        default: cycle(r, s, r ? "R5" : "R1");
      endcase
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule